// File: doc/BRIEF.md
# Superscalar Issue Unit Allocator

This block sits between instruction decode and the execution pipes of an in-order superscalar core. Each cycle it looks at up to four decoded instructions, oldest in slot 0, and assigns each one to one of six function units: two load/store pipes, two integer execute pipes and two floating-point pipes. Every unit has a fixed place in a preference list for each instruction class. Some classes may use only one pipe. Execute and FP pipes are shared in pairs. One mode decides whether FP arithmetic may use both FP pipes or only one.

Slots are served strictly in order. The first valid slot that finds no free unit stalls, and so does every later valid slot. Decode uses the registered grant and stall vectors to retire the issued slots and hold the rest for the next cycle.

Top module: `issue_alloc`

## Requirements
- R1: Grant and stall outputs are registered and reflect the inputs sampled at the previous rising clock edge. A synchronous active-low reset clears every grant and stall bit.
- R2: Each slot has a 6-bit unit grant with bit 0 = load/store pipe 0, bit 1 = load/store pipe 1, bit 2 = execute pipe 0, bit 3 = execute pipe 1, bit 4 = FP pipe 0, bit 5 = FP pipe 1. A stalled slot has an all-zero grant. A valid slot either receives a non-zero grant or stalls.
- R3: Once a valid slot stalls, every later valid slot stalls even if a unit is free for it. Slots whose valid bit is low get no grant, no stall, and do not block later slots.
- R4: Execute pipe 0 and FP pipe 0 are never both granted in one cycle. Execute pipe 1 and FP pipe 1 are never both granted in one cycle. Class 0 (unknown) is the only exception.
- R5: Class codes and their integer pipe orders:
  - Class 9 (simple arithmetic/constant) tries load/store pipe 1, then execute pipe 1, then execute pipe 0.
  - Class 10 (shift, conditional move, nop) tries execute pipe 1, then execute pipe 0.
  - Class 11 (set-less-than, leading-zero count, trap) and class 1 (branch, jump, call) use only execute pipe 0.
  - Classes 12 (hi/lo move), 13 (multiply) and 14 (divide) use only execute pipe 1.
- R6: Load and prefetch placement:
  - Classes 2 (load/prefetch) and 3 (FP load) try load/store pipe 0, then load/store pipe 1.
  - Classes 4 (indexed FP load) and 5 (indexed prefetch) use only load/store pipe 1.
- R7: Stores take two units in the same cycle.
  - Class 6 (integer store) takes one load/store pipe and one execute pipe, in the order LS0+EX1, LS0+EX0, LS1+EX1, LS1+EX0.
  - Class 7 (FP store) takes one load/store pipe and one FP pipe, in the order LS0+FP1, LS0+FP0, LS1+FP1, LS1+FP0.
  - Class 8 (indexed FP store) takes LS1+FP1, or else LS1+FP0.
- R8: Class 15 (FP arithmetic) tries FP pipe 1 and then FP pipe 0 only while the 64-bit FP mode is high and the FP-exceptions input is low. In every other mode combination it uses only FP pipe 1.
- R9: Class 16 (FP compare) uses only FP pipe 1. Class 17 (move between integer and FP register files) uses only FP pipe 0.
- R10: Class 0 (unknown/multi) and every code from 18 to 31 take all six units (grant 0x3F). Such an instruction therefore issues only when no earlier slot in the cycle holds a unit.
- R11: No unit is granted to more than one slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NUM_SLOTS | Per-slot valid bit, slot 0 oldest |
| in_class | input | NUM_SLOTS*5 | Per-slot 5-bit class code, slot k at bits [5k+4:5k] |
| fp64_mode | input | 1 | High when FP code runs with 64-bit FP registers |
| fp_exc_en | input | 1 | High when FP exceptions are enabled |
| out_grant | output | NUM_SLOTS*6 | Per-slot unit grant, slot k at bits [6k+5:6k] |
| out_stall | output | NUM_SLOTS | Per-slot stall flag |

## Verification
Suppose the running busy mask or the stall chain between slots holds a wrong value. The error shows in the very next registered cycle in one of three ways: a unit granted twice, an execute/FP pair granted together, or a later slot issuing past a stalled one. A wrong preference order is different. It violates no invariant and shows only as a different one-hot grant. For that reason the vector table pins down exact grant values for every class under competing loads. A mode decode error shows only for FP arithmetic in the second slot that wants an FP pipe, so those rows run in all three mode combinations.

// File: rtl/issue_alloc_pkg.sv
// Package: shared unit indices, class codes and helpers for the issue allocator.
// Assumes six function units in fixed bit positions and 5-bit class codes.
package issue_alloc_pkg;

    localparam int NUM_UNITS = 6;
    localparam int CLASS_W   = 5;
    localparam int OPT_N     = 4;

    localparam int U_LS0 = 0;
    localparam int U_LS1 = 1;
    localparam int U_EX0 = 2;
    localparam int U_EX1 = 3;
    localparam int U_FP0 = 4;
    localparam int U_FP1 = 5;

    typedef logic [NUM_UNITS-1:0] umask_t;

    localparam umask_t M_LS0 = umask_t'(1) << U_LS0;
    localparam umask_t M_LS1 = umask_t'(1) << U_LS1;
    localparam umask_t M_EX0 = umask_t'(1) << U_EX0;
    localparam umask_t M_EX1 = umask_t'(1) << U_EX1;
    localparam umask_t M_FP0 = umask_t'(1) << U_FP0;
    localparam umask_t M_FP1 = umask_t'(1) << U_FP1;
    localparam umask_t M_ALL = '1;

    typedef enum logic [CLASS_W-1:0] {
        CLS_UNKNOWN  = 5'd0,
        CLS_BRANCH   = 5'd1,
        CLS_LOAD     = 5'd2,
        CLS_FPLOAD   = 5'd3,
        CLS_FPIDXLD  = 5'd4,
        CLS_PREFIDX  = 5'd5,
        CLS_STORE    = 5'd6,
        CLS_FPSTORE  = 5'd7,
        CLS_FPIDXST  = 5'd8,
        CLS_SIMPLE   = 5'd9,
        CLS_ALU      = 5'd10,
        CLS_ALU0     = 5'd11,
        CLS_HILO     = 5'd12,
        CLS_IMUL     = 5'd13,
        CLS_IDIV     = 5'd14,
        CLS_FPARITH  = 5'd15,
        CLS_FPCMP    = 5'd16,
        CLS_XFER     = 5'd17
    } iclass_e;

    // Units made unavailable by the pairwise execute/FP sharing rule.
    function automatic umask_t partner_block(input umask_t busy);
        umask_t p;
        p        = '0;
        p[U_EX0] = busy[U_FP0];
        p[U_FP0] = busy[U_EX0];
        p[U_EX1] = busy[U_FP1];
        p[U_FP1] = busy[U_EX1];
        return p;
    endfunction

endpackage

// File: rtl/issue_class_decode.sv
// Module: turns one slot's class code into an ordered list of candidate unit
// sets. Candidate 0 is the most preferred.
// Assumes unlisted codes behave as the unknown class.
module issue_class_decode
    import issue_alloc_pkg::*;
(
    input  logic [CLASS_W-1:0]               cls,
    input  logic                             fp_dual,
    output logic [OPT_N-1:0][NUM_UNITS-1:0]  opts,
    output logic [OPT_N-1:0]                 opt_en
);

    // Candidate table lookup per class.
    always_comb begin
        opts   = '0;
        opt_en = '0;
        case (iclass_e'(cls))
            CLS_BRANCH, CLS_ALU0: begin
                opts[0] = M_EX0;         opt_en = 4'b0001;
            end
            CLS_LOAD, CLS_FPLOAD: begin
                opts[0] = M_LS0;         opts[1] = M_LS1;
                opt_en  = 4'b0011;
            end
            CLS_FPIDXLD, CLS_PREFIDX: begin
                opts[0] = M_LS1;         opt_en = 4'b0001;
            end
            CLS_STORE: begin
                opts[0] = M_LS0 | M_EX1; opts[1] = M_LS0 | M_EX0;
                opts[2] = M_LS1 | M_EX1; opts[3] = M_LS1 | M_EX0;
                opt_en  = 4'b1111;
            end
            CLS_FPSTORE: begin
                opts[0] = M_LS0 | M_FP1; opts[1] = M_LS0 | M_FP0;
                opts[2] = M_LS1 | M_FP1; opts[3] = M_LS1 | M_FP0;
                opt_en  = 4'b1111;
            end
            CLS_FPIDXST: begin
                opts[0] = M_LS1 | M_FP1; opts[1] = M_LS1 | M_FP0;
                opt_en  = 4'b0011;
            end
            CLS_SIMPLE: begin
                opts[0] = M_LS1;         opts[1] = M_EX1;
                opts[2] = M_EX0;         opt_en  = 4'b0111;
            end
            CLS_ALU: begin
                opts[0] = M_EX1;         opts[1] = M_EX0;
                opt_en  = 4'b0011;
            end
            CLS_HILO, CLS_IMUL, CLS_IDIV: begin
                opts[0] = M_EX1;         opt_en = 4'b0001;
            end
            CLS_FPARITH: begin
                opts[0] = M_FP1;         opts[1] = M_FP0;
                opt_en  = {2'b00, fp_dual, 1'b1};
            end
            CLS_FPCMP: begin
                opts[0] = M_FP1;         opt_en = 4'b0001;
            end
            CLS_XFER: begin
                opts[0] = M_FP0;         opt_en = 4'b0001;
            end
            default: begin
                opts[0] = M_ALL;         opt_en = 4'b0001;
            end
        endcase
    end

endmodule

// File: rtl/issue_slot_pick.sv
// Module: picks the first candidate unit set that fits among the units still
// free. Accounts for units already taken and for execute/FP pair sharing.
// Assumes candidate 0 has the highest preference.
module issue_slot_pick
    import issue_alloc_pkg::*;
(
    input  logic [NUM_UNITS-1:0]             busy,
    input  logic [OPT_N-1:0][NUM_UNITS-1:0]  opts,
    input  logic [OPT_N-1:0]                 opt_en,
    output logic [NUM_UNITS-1:0]             take,
    output logic                             fit
);

    logic [NUM_UNITS-1:0] blocked;

    // Units that are taken or locked out by their sharing partner.
    always_comb blocked = busy | partner_block(busy);

    // First fitting candidate in preference order.
    always_comb begin
        take = '0;
        fit  = 1'b0;
        for (int o = 0; o < OPT_N; o++) begin
            if (!fit && opt_en[o] && ((opts[o] & blocked) == '0)) begin
                take = opts[o];
                fit  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/issue_alloc.sv
// Module: in-order issue allocator. Slot 0 is oldest. Each valid slot gets the
// first free unit set in its class order, or stalls along with all later valid
// slots. Results are registered.
// Assumes in_class and the mode inputs are stable around the clock edge.
module issue_alloc
    import issue_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SLOTS-1:0]           in_valid,
    input  logic [NUM_SLOTS*CLASS_W-1:0]   in_class,
    input  logic                           fp64_mode,
    input  logic                           fp_exc_en,
    output logic [NUM_SLOTS*NUM_UNITS-1:0] out_grant,
    output logic [NUM_SLOTS-1:0]           out_stall
);

    localparam int GRANT_W = NUM_SLOTS * NUM_UNITS;

    logic                                          fp_dual;
    logic [NUM_SLOTS-1:0][OPT_N-1:0][NUM_UNITS-1:0] opts_all;
    logic [NUM_SLOTS-1:0][OPT_N-1:0]                en_all;
    logic [NUM_SLOTS-1:0][NUM_UNITS-1:0]            take_all;
    logic [NUM_SLOTS-1:0]                           fit_all;
    logic [NUM_UNITS-1:0]                           busy_chain [NUM_SLOTS+1];
    logic                                           stop_chain [NUM_SLOTS+1];
    logic [NUM_SLOTS-1:0][NUM_UNITS-1:0]            grant_c;
    logic [NUM_SLOTS-1:0]                           stall_c;

    // Both FP pipes are usable only in 64-bit mode with exceptions off.
    always_comb fp_dual = fp64_mode & ~fp_exc_en;

    // Chain seeds: nothing taken, nothing stalled ahead of slot 0.
    always_comb begin
        busy_chain[0] = '0;
        stop_chain[0] = 1'b0;
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        issue_class_decode u_dec (
            .cls     (in_class[k*CLASS_W +: CLASS_W]),
            .fp_dual (fp_dual),
            .opts    (opts_all[k]),
            .opt_en  (en_all[k])
        );

        issue_slot_pick u_pick (
            .busy    (busy_chain[k]),
            .opts    (opts_all[k]),
            .opt_en  (en_all[k]),
            .take    (take_all[k]),
            .fit     (fit_all[k])
        );

        // Slot outcome, then pass taken units and stall state to the next slot.
        always_comb begin
            grant_c[k]        = (in_valid[k] && !stop_chain[k] && fit_all[k])
                                ? take_all[k] : '0;
            stall_c[k]        = in_valid[k] && (stop_chain[k] || !fit_all[k]);
            busy_chain[k+1]   = busy_chain[k] | grant_c[k];
            stop_chain[k+1]   = stop_chain[k] | stall_c[k];
        end
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_grant <= '0;
            out_stall <= '0;
        end else begin
            out_grant <= GRANT_W'(grant_c);
            out_stall <= stall_c;
        end
    end

endmodule

// File: rtl/issue_alloc_checker.sv
// Module: property checker for issue_alloc, attached by bind.
// Assumes the same NUM_SLOTS as the checked instance.
module issue_alloc_checker
    import issue_alloc_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SLOTS-1:0]           in_valid,
    input logic [NUM_SLOTS*CLASS_W-1:0]   in_class,
    input logic                           fp64_mode,
    input logic                           fp_exc_en,
    input logic [NUM_SLOTS*NUM_UNITS-1:0] out_grant,
    input logic [NUM_SLOTS-1:0]           out_stall
);

    logic                 armed        = 1'b0;
    logic                 past_rst_low = 1'b0;
    logic [NUM_UNITS-1:0] grant_or;
    logic                 any_all;

    // Tracks whether a clock edge has passed and what reset was at it.
    always_ff @(posedge clk) begin
        armed        <= 1'b1;
        past_rst_low <= !rst_n;
    end

    // Union of grants, and whether any slot holds all units.
    always_comb begin
        grant_or = '0;
        any_all  = 1'b0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            grant_or = grant_or | out_grant[k*NUM_UNITS +: NUM_UNITS];
            if (out_grant[k*NUM_UNITS +: NUM_UNITS] == M_ALL) any_all = 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        (armed && past_rst_low) |-> (out_grant == '0 && out_stall == '0));

    p_pair_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_all |-> !(grant_or[U_EX0] && grant_or[U_FP0])
                  && !(grant_or[U_EX1] && grant_or[U_FP1]));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        p_stall_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_stall[k] |-> out_grant[k*NUM_UNITS +: NUM_UNITS] == '0);

        p_valid_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid[k]))
                |-> (out_stall[k] || out_grant[k*NUM_UNITS +: NUM_UNITS] != '0));

        p_fp_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid[k])
             && $past(in_class[k*CLASS_W +: CLASS_W]) == CLS_FPARITH
             && !$past(fp64_mode && !fp_exc_en)
             && out_grant[k*NUM_UNITS +: NUM_UNITS] != '0)
                |-> out_grant[k*NUM_UNITS +: NUM_UNITS] == M_FP1);

        p_idx_ls1_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_valid[k])
             && ($past(in_class[k*CLASS_W +: CLASS_W]) == CLS_FPIDXLD
              || $past(in_class[k*CLASS_W +: CLASS_W]) == CLS_PREFIDX))
                |-> !out_grant[k*NUM_UNITS + U_LS0]);

        for (genvar j = k + 1; j < NUM_SLOTS; j++) begin : g_pair
            p_unit_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (out_grant[k*NUM_UNITS +: NUM_UNITS]
                 & out_grant[j*NUM_UNITS +: NUM_UNITS]) == '0);

            p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
                out_stall[k] |-> out_grant[j*NUM_UNITS +: NUM_UNITS] == '0);
        end
    end

endmodule

bind issue_alloc issue_alloc_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .fp64_mode (fp64_mode),
    .fp_exc_en (fp_exc_en),
    .out_grant (out_grant),
    .out_stall (out_stall)
);

// File: tb/issue_alloc_bench.sv
// Bench: walks a vector table of bundles with expected grants, then runs
// directed checks for reset and output timing.
module issue_alloc_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS  = 4;
    localparam int N   = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_valid = '0;
    logic [19:0] in_class = '0;
    logic        fp64_mode = 1'b0;
    logic        fp_exc_en = 1'b1;
    logic [23:0] out_grant;
    logic [3:0]  out_stall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_alloc #(.NUM_SLOTS(NS)) u_issue_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_class  (in_class),
        .fp64_mode (fp64_mode),
        .fp_exc_en (fp_exc_en),
        .out_grant (out_grant),
        .out_stall (out_stall)
    );

    // Class codes per slot {s3,s2,s1,s0}; grants {g3,g2,g1,g0}.
    localparam logic [3:0] TV_VALID [N] = '{
        4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
        4'hF, 4'hF, 4'hF, 4'b0101, 4'h0, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
        4'b1101};
    localparam logic [19:0] TV_CLASS [N] = '{
        {5'd9,  5'd9,  5'd9,  5'd9 },   // R5 simple alu x4
        {5'd1,  5'd2,  5'd2,  5'd2 },   // R6 three loads, R3
        {5'd1,  5'd15, 5'd15, 5'd15},   // R8 dual FP
        {5'd2,  5'd1,  5'd15, 5'd15},   // R8 exceptions on
        {5'd2,  5'd2,  5'd15, 5'd15},   // R8 32-bit mode
        {5'd2,  5'd2,  5'd17, 5'd1 },   // R4 EX0 vs FP0, R9
        {5'd2,  5'd2,  5'd16, 5'd12},   // R4 EX1 vs FP1, R9
        {5'd2,  5'd10, 5'd6,  5'd6 },   // R7 integer stores
        {5'd1,  5'd2,  5'd7,  5'd7 },   // R7 FP stores
        {5'd10, 5'd10, 5'd5,  5'd4 },   // R6 indexed on LS1 only
        {5'd13, 5'd11, 5'd4,  5'd2 },   // R6 R5 full bundle
        {5'd2,  5'd2,  5'd2,  5'd0 },   // R10 unknown first
        {5'd2,  5'd2,  5'd0,  5'd2 },   // R10 unknown second
        {5'd1,  5'd1,  5'd1,  5'd1 },   // R3 invalid holes
        {5'd9,  5'd9,  5'd9,  5'd9 },   // R3 nothing valid
        {5'd9,  5'd10, 5'd9,  5'd10},   // R5 orders
        {5'd2,  5'd15, 5'd6,  5'd8 },   // R7 R4 indexed FP store
        {5'd2,  5'd2,  5'd2,  5'd31},   // R10 reserved code
        {5'd2,  5'd9,  5'd15, 5'd17},   // R9 R8 xfer + single FP
        {5'd2,  5'd10, 5'd1,  5'd14},   // R5 R3 divide
        {5'd1,  5'd2,  5'd2,  5'd2 }};  // R3 hole not blocking
    localparam logic [1:0] TV_MODE [N] = '{   // {fp64_mode, fp_exc_en}
        2'b01, 2'b01, 2'b10, 2'b11, 2'b00, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
        2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b10, 2'b01, 2'b01, 2'b01,
        2'b01};
    localparam logic [23:0] TV_GRANT [N] = '{
        {6'h00, 6'h04, 6'h08, 6'h02},
        {6'h00, 6'h00, 6'h02, 6'h01},
        {6'h00, 6'h00, 6'h10, 6'h20},
        {6'h00, 6'h00, 6'h00, 6'h20},
        {6'h00, 6'h00, 6'h00, 6'h20},
        {6'h00, 6'h00, 6'h00, 6'h04},
        {6'h00, 6'h00, 6'h00, 6'h08},
        {6'h00, 6'h00, 6'h06, 6'h09},
        {6'h00, 6'h00, 6'h12, 6'h21},
        {6'h00, 6'h00, 6'h00, 6'h02},
        {6'h08, 6'h04, 6'h02, 6'h01},
        {6'h00, 6'h00, 6'h00, 6'h3F},
        {6'h00, 6'h00, 6'h00, 6'h01},
        {6'h00, 6'h00, 6'h00, 6'h04},
        {6'h00, 6'h00, 6'h00, 6'h00},
        {6'h00, 6'h04, 6'h02, 6'h08},
        {6'h00, 6'h00, 6'h05, 6'h22},
        {6'h00, 6'h00, 6'h00, 6'h3F},
        {6'h01, 6'h02, 6'h20, 6'h10},
        {6'h00, 6'h00, 6'h04, 6'h08},
        {6'h04, 6'h02, 6'h00, 6'h01}};
    localparam logic [3:0] TV_STALL [N] = '{
        4'b1000, 4'b1100, 4'b1100, 4'b1110, 4'b1110, 4'b1110, 4'b1110,
        4'b1100, 4'b1100, 4'b1110, 4'b0000, 4'b1110, 4'b1110, 4'b0100,
        4'b0000, 4'b1000, 4'b1100, 4'b1110, 4'b0000, 4'b1100, 4'b0000};
    localparam logic [63:0] TV_REQ [N] = '{
        "R5 R3", "R6 R3", "R8", "R8", "R8", "R4 R9", "R4 R9", "R7", "R7",
        "R6", "R6 R5", "R10", "R10", "R3", "R3", "R5", "R7 R4", "R10",
        "R9 R8", "R5 R3", "R3"};

    task automatic check(input logic [63:0] req, input logic [23:0] eg,
                         input logic [3:0] es);
        checks++;
        if (out_grant !== eg || out_stall !== es) begin
            errors++;
            $display("FAIL %s: grant=%h stall=%b expected grant=%h stall=%b",
                     req, out_grant, out_stall, eg, es);
        end
    endtask

    task automatic apply(input int i);
        in_valid  = TV_VALID[i];
        in_class  = TV_CLASS[i];
        fp64_mode = TV_MODE[i][1];
        fp_exc_en = TV_MODE[i][0];
    endtask

    initial begin
        // R1: reset held with an active bundle gives all-zero outputs.
        apply(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 24'h0, 4'h0);
        rst_n = 1'b1;

        // Table walk: drive at negedge, result visible after the next edge.
        for (int i = 0; i < N; i++) begin
            apply(i);
            @(posedge clk);
            @(negedge clk);
            check(TV_REQ[i], TV_GRANT[i], TV_STALL[i]);
        end

        // R1: a new bundle does not change outputs before the next edge.
        apply(10);
        @(posedge clk);
        @(negedge clk);
        apply(11);
        #1;
        check("R1", TV_GRANT[10], TV_STALL[10]);
        @(posedge clk);
        @(negedge clk);
        check("R1", TV_GRANT[11], TV_STALL[11]);

        // R1: synchronous reset mid-stream clears outputs at the edge.
        apply(10);
        rst_n = 1'b0;
        #1;
        check("R1", TV_GRANT[11], TV_STALL[11]);
        @(posedge clk);
        @(negedge clk);
        check("R1", 24'h0, 4'h0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", TV_GRANT[10], TV_STALL[10]);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R1: watchdog expired, got no end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule